// File: doc/BRIEF.md
# Burst Serial Word Transmitter

This block sends 32-bit words out over a three-wire synchronous link: a serial clock, a data line and an active-low select. Words come in on a parallel port with a valid/ready handshake. Every accepted word is cut into one 32-bit package or four 8-bit packages. Each package goes out most significant bit first. Data changes when the serial clock falls, so the receiver can sample it on the rising edge.

The serial clock comes from the system clock. The design assumes a 16 MHz system clock, which is divided by 2 or by 4. An optional idle stretch of seven serial periods can follow every package. During that stretch the serial clock stays high and the select stays low. A burst begins when a word is accepted while the block is idle. The burst goes on for as long as a new word is waiting at the moment the previous word completes. The three configuration inputs are latched when a burst begins.

Top module: `sstream_tx`

## Requirements
- R1: While a word is being shifted, one serial period lasts 2 system clocks when `cfg_slow` is 0 and 4 system clocks when it is 1. The serial clock is low for the first half of each period and high for the second half. It idles high.
- R2: With `cfg_bytes` at 0 a word goes out as one package of 32 bits. With `cfg_bytes` at 1 it goes out as four packages of 8 bits.
- R3: Bits leave most significant first, and this holds across package boundaries. `sdata` changes only when `sclk` falls or when `ssel_n` rises. It is 0 while idle.
- R4: With `cfg_gap` at 1, every package (including the last package of a word) is followed by seven serial periods. In these periods `sclk` stays high, `ssel_n` stays low and `sdata` keeps the last bit sent. With `cfg_gap` at 0, packages and words follow each other with no idle period.
- R5: `ssel_n` goes low in the cycle after the first word of a burst is accepted. It stays low for the whole burst. It goes high one serial period after the final word completes, and `sclk` is high during that period.
- R6: A word is taken when `in_valid` and `in_ready` are both 1 at a clock edge. If a word is offered in the cycle where the previous word completes, its first bit follows at once, within the same burst.
- R7: `in_ready` is 1 while the block is idle, and in the last system clock of a word (the end of its final bit, or the end of its trailing gap when gaps are on). It is 0 at all other times.
- R8: The values of `cfg_slow`, `cfg_bytes` and `cfg_gap` are captured when a burst starts. Changing them before the burst ends has no effect on that burst.
- R9: After reset, `sclk` is 1, `sdata` is 0, `ssel_n` is 1 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (16 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slow | input | 1 | Serial clock rate: 0 = system/2, 1 = system/4 |
| cfg_bytes | input | 1 | Package size: 0 = 32 bits, 1 = 8 bits |
| cfg_gap | input | 1 | 1 = seven-period idle stretch after each package |
| in_valid | input | 1 | A word is offered on `in_data` |
| in_data | input | 32 | Word to transmit |
| in_ready | output | 1 | Block accepts a word at this edge |
| sclk | output | 1 | Serial clock, idle high |
| sdata | output | 1 | Serial data, valid on rising `sclk` |
| ssel_n | output | 1 | Active-low select, low for the whole burst |

## Verification
The assertions assume that `rst` is held for at least one edge before the first use. They also assume that `in_valid`, `in_data` and the configuration inputs change only between clock edges, and never in step with the edge that samples them. The bench drives every input one time unit after the rising edge. It keeps `in_valid` high until it sees `in_ready` at the falling edge. It changes the configuration in the middle of a burst only in the case that tests it. So every handshake the model predicts is also the handshake the design sees.

// File: rtl/sstream_pkg.sv
package sstream_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2,
        ST_TAIL  = 2'd3
    } st_e;

    typedef struct packed {
        logic slow;
        logic bytes;
        logic gap;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{slow: 1'b0, bytes: 1'b0, gap: 1'b0};

    function automatic logic clk_held_high(st_e s);
        return (s == ST_IDLE) || (s == ST_GAP) || (s == ST_TAIL);
    endfunction

endpackage

// File: rtl/sstream_tick.sv
module sstream_tick #(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hold_hi,
    input  logic slow,
    output logic period_end,
    output logic sclk
);
    localparam int PH_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PH_W-1:0] FAST_LIM  = PH_W'(FAST_DIV - 1);
    localparam logic [PH_W-1:0] SLOW_LIM  = PH_W'(SLOW_DIV - 1);
    localparam logic [PH_W-1:0] FAST_HALF = PH_W'(FAST_DIV / 2);
    localparam logic [PH_W-1:0] SLOW_HALF = PH_W'(SLOW_DIV / 2);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] lim;
    logic [PH_W-1:0] half;

    assign lim        = slow ? SLOW_LIM : FAST_LIM;
    assign half       = slow ? SLOW_HALF : FAST_HALF;
    assign period_end = run && (ph_q == lim);
    assign sclk       = hold_hi || (ph_q >= half);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_q <= '0;
        end else if (period_end) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // R1
    period_hi_chk: assert property (@(posedge clk) disable iff (rst)
        period_end |-> sclk);

endmodule

// File: rtl/sstream_seq.sv
module sstream_seq
    import sstream_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int PKG_W       = 8,
    parameter int GAP_PERIODS = 7
) (
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_in,
    input  logic in_valid,
    input  logic period_end,
    output st_e  st,
    output cfg_t cfg_q,
    output logic in_ready,
    output logic load,
    output logic shift_en,
    output logic tail_end
);
    localparam int PKG_N = WORD_W / PKG_W;
    localparam int BIT_W = $clog2(WORD_W);
    localparam int PC_W  = (PKG_N > 1) ? $clog2(PKG_N) : 1;
    localparam int GAP_W = $clog2(GAP_PERIODS + 1);
    localparam logic [BIT_W-1:0] BITS_FULL = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] BITS_PKG  = BIT_W'(PKG_W - 1);
    localparam logic [PC_W-1:0]  PKGS_LAST = PC_W'(PKG_N - 1);
    localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(GAP_PERIODS - 1);

    st_e              st_q;
    logic [BIT_W-1:0] bit_q;
    logic [PC_W-1:0]  pkg_q;
    logic [GAP_W-1:0] gap_q;
    logic             gap_word_q;
    cfg_t             cfg_r;
    cfg_t             new_cfg;
    logic             last_bit;
    logic             last_pkg;
    logic             word_end;

    assign st       = st_q;
    assign cfg_q    = cfg_r;
    assign new_cfg  = (st_q == ST_IDLE) ? cfg_in : cfg_r;
    assign last_bit = (bit_q == '0);
    assign last_pkg = (pkg_q == '0);

    // R7: a word is complete at the end of its final bit, or of its trailing gap
    assign word_end = period_end &&
        (((st_q == ST_SHIFT) && last_bit && last_pkg && !cfg_r.gap) ||
         ((st_q == ST_GAP) && (gap_q == '0) && gap_word_q));
    assign in_ready = (st_q == ST_IDLE) || word_end;
    assign load     = in_valid && in_ready;
    assign shift_en = (st_q == ST_SHIFT) && period_end;
    assign tail_end = (st_q == ST_TAIL) && period_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cfg_r      <= CFG_RESET;
            bit_q      <= '0;
            pkg_q      <= '0;
            gap_q      <= '0;
            gap_word_q <= 1'b0;
        end else if (load) begin
            // R6: new word, possibly inside a running burst
            st_q  <= ST_SHIFT;
            bit_q <= new_cfg.bytes ? BITS_PKG : BITS_FULL;
            pkg_q <= new_cfg.bytes ? PKGS_LAST : '0;
            if (st_q == ST_IDLE) begin
                cfg_r <= cfg_in;
            end
        end else begin
            unique case (st_q)
                ST_SHIFT: if (period_end) begin
                    if (!last_bit) begin
                        bit_q <= bit_q - 1'b1;
                    end else if (!last_pkg) begin
                        pkg_q <= pkg_q - 1'b1;
                        bit_q <= BITS_PKG;
                        if (cfg_r.gap) begin
                            st_q       <= ST_GAP;
                            gap_q      <= GAP_LAST;
                            gap_word_q <= 1'b0;
                        end
                    end else if (cfg_r.gap) begin
                        st_q       <= ST_GAP;
                        gap_q      <= GAP_LAST;
                        gap_word_q <= 1'b1;
                    end else begin
                        st_q <= ST_TAIL;
                    end
                end
                ST_GAP: if (period_end) begin
                    if (gap_q != '0) begin
                        gap_q <= gap_q - 1'b1;
                    end else if (gap_word_q) begin
                        st_q <= ST_TAIL;
                    end else begin
                        st_q <= ST_SHIFT;
                    end
                end
                ST_TAIL: if (period_end) begin
                    st_q <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q != ST_IDLE) && $past(st_q != ST_IDLE)) |-> $stable(cfg_r));

    // R2
    pkg_range_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_SHIFT) && cfg_r.bytes) |-> (bit_q <= BITS_PKG));

endmodule

// File: rtl/sstream_shift.sv
module sstream_shift
    import sstream_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  st_e               st,
    input  logic              load,
    input  logic              shift_en,
    input  logic              tail_end,
    input  logic [WORD_W-1:0] in_data,
    output logic              sdata
);
    logic [WORD_W-1:0] sh_q;
    logic              held_q;

    assign sdata = (st == ST_SHIFT) ? sh_q[WORD_W-1] : held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            held_q <= 1'b0;
        end else begin
            if (load) begin
                sh_q <= in_data;
            end else if (shift_en) begin
                sh_q <= {sh_q[WORD_W-2:0], 1'b0};
            end
            if (st == ST_SHIFT) begin
                held_q <= sh_q[WORD_W-1];
            end else if (tail_end || (st == ST_IDLE)) begin
                held_q <= 1'b0;
            end
        end
    end

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_IDLE) && $past(st == ST_IDLE)) |-> !sdata);

endmodule

// File: rtl/sstream_tx.sv
module sstream_tx
    import sstream_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int PKG_W       = 8,
    parameter int GAP_PERIODS = 7,
    parameter int FAST_DIV    = 2,
    parameter int SLOW_DIV    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_slow,
    input  logic              cfg_bytes,
    input  logic              cfg_gap,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              sclk,
    output logic              sdata,
    output logic              ssel_n
);
    st_e  st;
    cfg_t cfg_in;
    cfg_t cfg_q;
    logic load;
    logic shift_en;
    logic tail_end;
    logic period_end;

    assign cfg_in = '{slow: cfg_slow, bytes: cfg_bytes, gap: cfg_gap};
    assign ssel_n = (st == ST_IDLE);

    sstream_seq #(
        .WORD_W      (WORD_W),
        .PKG_W       (PKG_W),
        .GAP_PERIODS (GAP_PERIODS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_in     (cfg_in),
        .in_valid   (in_valid),
        .period_end (period_end),
        .st         (st),
        .cfg_q      (cfg_q),
        .in_ready   (in_ready),
        .load       (load),
        .shift_en   (shift_en),
        .tail_end   (tail_end)
    );

    sstream_tick #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_tick (
        .clk        (clk),
        .rst        (rst),
        .run        (st != ST_IDLE),
        .hold_hi    (clk_held_high(st)),
        .slow       (cfg_q.slow),
        .period_end (period_end),
        .sclk       (sclk)
    );

    sstream_shift #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .load     (load),
        .shift_en (shift_en),
        .tail_end (tail_end),
        .in_data  (in_data),
        .sdata    (sdata)
    );

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (ssel_n && sclk && in_ready && !sdata));

    // R5
    sel_low_chk: assert property (@(posedge clk) disable iff (rst)
        !sclk |-> !ssel_n);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk) && !ssel_n) |-> $stable(sdata));

    // R7
    ready_sclk_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> sclk);

endmodule

// File: tb/test_sstream_tx.sv
module test_sstream_tx;

    typedef struct packed {
        logic sc;
        logic sd;
        logic sel;
        logic rdy;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_slow = 1'b0;
    logic        cfg_bytes = 1'b0;
    logic        cfg_gap = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        sclk;
    logic        sdata;
    logic        ssel_n;

    int    total = 0;
    int    bad = 0;
    string tag = "R9";
    exp_t  q[$];
    logic  b_slow = 1'b0;
    logic  b_bytes = 1'b0;
    logic  b_gap = 1'b0;
    logic  last_bit = 1'b0;

    always #4 clk = ~clk;

    sstream_tx i_sstream_tx (
        .clk       (clk),
        .rst       (rst),
        .cfg_slow  (cfg_slow),
        .cfg_bytes (cfg_bytes),
        .cfg_gap   (cfg_gap),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .sclk      (sclk),
        .sdata     (sdata),
        .ssel_n    (ssel_n)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s %s at %0t: actual=%b expected=%b", tag, req, what, $time, act, exp);
        end
    endtask

    task automatic put(input logic sc, input logic sd);
        exp_t e;
        e.sc = sc; e.sd = sd; e.sel = 1'b0; e.rdy = 1'b0;
        q.push_back(e);
    endtask

    // Expected line activity for one word under the latched burst settings
    task automatic add_word(input logic [31:0] w);
        int   h;
        int   np;
        int   nb;
        int   k;
        exp_t t;
        h  = b_slow ? 2 : 1;
        np = b_bytes ? 4 : 1;
        nb = b_bytes ? 8 : 32;
        k  = 0;
        for (int p = 0; p < np; p++) begin
            for (int b = 0; b < nb; b++) begin
                last_bit = w[31 - k];
                k++;
                for (int c = 0; c < h; c++) put(1'b0, last_bit);
                for (int c = 0; c < h; c++) put(1'b1, last_bit);
            end
            if (b_gap) begin
                for (int c = 0; c < 14 * h; c++) put(1'b1, last_bit);
            end
        end
        t = q[$];
        void'(q.pop_back());
        t.rdy = 1'b1;
        q.push_back(t);
    endtask

    task automatic add_tail();
        int h;
        h = b_slow ? 2 : 1;
        for (int c = 0; c < 2 * h; c++) put(1'b1, last_bit);
    endtask

    // Reference model, compared on every clock
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (q.size() == 0) begin
                e = '{sc: 1'b1, sd: 1'b0, sel: 1'b1, rdy: 1'b1};
            end else begin
                e = q.pop_front();
            end
            check(sclk,     e.sc,  "R1", "sclk");
            check(sdata,    e.sd,  "R3", "sdata");
            check(ssel_n,   e.sel, "R5", "ssel_n");
            check(in_ready, e.rdy, "R7", "in_ready");
            if (e.rdy && in_valid) begin
                if (e.sel) begin
                    b_slow  = cfg_slow;
                    b_bytes = cfg_bytes;
                    b_gap   = cfg_gap;
                end
                add_word(in_data);
            end else if (e.rdy && !e.sel) begin
                add_tail();
            end
        end
    end

    task automatic push(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!ssel_n || q.size() != 0);
        repeat (3) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic s, input logic b, input logic g);
        cfg_slow  = s;
        cfg_bytes = b;
        cfg_gap   = g;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        tag = "R9";
        repeat (4) @(posedge clk);
        #1;

        tag = "R1_R2_R3_R5";
        set_cfg(1'b0, 1'b0, 1'b0);
        push(32'hA5C3_0F96);
        wait_idle();

        tag = "R1_slow";
        set_cfg(1'b1, 1'b0, 1'b0);
        push(32'h8000_0001);
        wait_idle();

        tag = "R2_bytes";
        set_cfg(1'b0, 1'b1, 1'b0);
        push(32'h1234_5678);
        wait_idle();

        tag = "R4_bytes_gap";
        set_cfg(1'b1, 1'b1, 1'b1);
        push(32'hF00F_C33C);
        wait_idle();

        tag = "R4_word_gap";
        set_cfg(1'b0, 1'b0, 1'b1);
        push(32'hFFFF_FFFF);
        wait_idle();

        tag = "R6_R7_burst";
        set_cfg(1'b0, 1'b0, 1'b0);
        push(32'hDEAD_BEEF);
        push(32'h0000_0000);
        push(32'h7FFF_FFFE);
        wait_idle();

        tag = "R6_R4_burst_gap";
        set_cfg(1'b1, 1'b1, 1'b1);
        push(32'h0102_0304);
        push(32'h8040_2010);
        wait_idle();

        tag = "R8_cfg_change";
        set_cfg(1'b1, 1'b1, 1'b1);
        push(32'hC0FF_EE11);
        set_cfg(1'b0, 1'b0, 1'b0);
        push(32'h5555_AAAA);
        wait_idle();
        push(32'h9696_6969);
        wait_idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule